// File: doc/BRIEF.md
# Fusible Event Counter Bank

This block holds a bank of event counters for performance monitoring. Each counter has its own control register and its own 48-bit count register. Every clock cycle it takes a 4-bit increment from upstream event logic. The counters sit in adjacent pairs, an even one and the odd one above it. A pair can be fused so that it accepts a larger per-cycle increment and keeps a wider count. Software sets up and reads the bank through a simple single-cycle register port.

To fuse a pair, software first writes the reserved event code 0xFFF, with the enable bit set, into the odd counter's control register. It then enables the even counter with the real event. From that point the pair adds both 4-bit inputs together each cycle into one 64-bit total. The low 48 bits of that total live in the even count register and the top 16 bits live in the low 16 bits of the odd count register. If software enables the even counter before the odd one is set up for fusing, the even counter keeps working as an ordinary 48-bit counter.

Top module: `evctr_bank`

## Requirements
- R1: A synchronous active-low reset clears every control register, every count register and every fused-pair state. After reset, every register reads as zero.
- R2: A control register holds four fields: event low byte at bits 7:0, unit mask at bits 15:8, event high nibble at bits 19:16 and enable at bit 20. The 12-bit event code is {bits 19:16, bits 7:0}. A read returns the stored fields, and bits 63:21 read as zero.
- R3: An enabled counter that is not part of a fused pair adds its own 4-bit input once per clock. The sum wraps modulo 2^48.
- R4: A counter whose enable bit is clear holds its count while its input is non-zero.
- R5: An odd counter whose control holds enable=1 and event code 0xFFF is in fusing setup. In that state it never counts its own input.
- R6: If the even counter's control is written with enable=1 while its odd partner is in fusing setup, the pair becomes fused. From the next clock the pair adds the sum of both inputs (0 to 30) to a 64-bit value each cycle. That value is {odd count bits 15:0, even count bits 47:0}, and a carry out of bit 47 moves into the odd field in the same cycle.
- R7: If the even counter is enabled before its partner enters fusing setup, it stays an ordinary 48-bit counter. It fuses only when its control is written again with enable=1 while the partner is in setup.
- R8: A count read of a fused even counter returns all 64 bits. Any other count read returns the 48-bit register zero-extended.
- R9: A count write stores only data bits 47:0 in the addressed register. The top field of a fused value is written through the odd counter's count register.
- R10: A count write wins over that cycle's increment. In a fused pair, a count write to either half drops the whole pair's increment for that cycle.
- R11: A pair stops being fused when its even control is written with enable=0, or when its odd control is written with a value that is not fusing setup.
- R12: Register address bits 3:1 select the counter and bit 0 selects the control (0) or count (1) register. Counter indices 6 and 7 are ignored on write and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: counter index in bits 3:1, control/count select in bit 0 |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from the address |
| ev_inc | input | 24 | Per-counter 4-bit increments, counter k in bits 4k+3:4k |

## Verification
The bench builds the bank with its default parameters: six counters in three pairs, 48-bit count registers, a 16-bit upper field and 4-bit inputs. With these values the bench presets counts close to 2^48 and 2^64 through ordinary register writes. That makes the 48-bit wrap and the carry from bit 47 into the odd field reachable in a few cycles. The three pairs also let one bench run fused, unfused and wrongly ordered pairs side by side, while random register traffic switches pairs in and out of the fused state.

// File: rtl/evctr_pkg.sv
// Shared types for the event counter bank.
// Assumes the control register layout is fixed by software convention;
// only the counter widths are parameters of the modules that use it.
package evctr_pkg;

    typedef struct packed {
        logic       en;      // bit 20
        logic [3:0] evt_hi;  // bits 19:16
        logic [7:0] umask;   // bits 15:8
        logic [7:0] evt_lo;  // bits 7:0
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
    localparam logic [11:0] FUSE_CODE = 12'hFFF;

    // True when a control value puts an odd counter into fusing setup
    function automatic logic is_fuse_setup(input ctl_t c);
        return c.en && ({c.evt_hi, c.evt_lo} == FUSE_CODE);
    endfunction

endpackage

// File: rtl/evctr_pair.sv
// One even/odd counter pair with its two control registers and fuse state.
// Assumes at most one of ctl_we/cnt_we is set per cycle (single register port).
// Fused: 64-bit value {odd[EXT_W-1:0], even} advances by both inputs.
module evctr_pair #(
    parameter int CTR_W = 48,
    parameter int EXT_W = 16,
    parameter int INC_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          ctl_we,
    input  logic [1:0]          cnt_we,
    input  logic [CTR_W-1:0]    wdata,
    input  logic [INC_W-1:0]    inc_even,
    input  logic [INC_W-1:0]    inc_odd,
    output evctr_pkg::ctl_t     ctl_e_q,
    output evctr_pkg::ctl_t     ctl_o_q,
    output logic [CTR_W-1:0]    cnt_e_q,
    output logic [CTR_W-1:0]    cnt_o_q,
    output logic                fused_q
);
    import evctr_pkg::*;

    localparam int FULL_W = CTR_W + EXT_W;

    ctl_t              wr_ctl;
    logic              odd_setup;
    logic              pair_wr;
    logic [FULL_W-1:0] fused_sum;
    logic [CTR_W-1:0]  nxt_e;
    logic [CTR_W-1:0]  nxt_o;

    assign wr_ctl    = ctl_t'(wdata[CTL_W-1:0]);
    assign odd_setup = is_fuse_setup(ctl_o_q);
    assign pair_wr   = |cnt_we;
    assign fused_sum = {cnt_o_q[EXT_W-1:0], cnt_e_q}
                     + FULL_W'(inc_even) + FULL_W'(inc_odd);

    // Next count values: increment by mode, then let register writes win
    always_comb begin
        nxt_e = cnt_e_q;
        nxt_o = cnt_o_q;
        if (fused_q) begin
            if (ctl_e_q.en && !pair_wr) begin
                nxt_e              = fused_sum[CTR_W-1:0];
                nxt_o[EXT_W-1:0]   = fused_sum[FULL_W-1:CTR_W];
            end
        end else begin
            if (ctl_e_q.en)
                nxt_e = cnt_e_q + CTR_W'(inc_even);
            if (ctl_o_q.en && !odd_setup)
                nxt_o = cnt_o_q + CTR_W'(inc_odd);
        end
        if (cnt_we[0]) nxt_e = wdata;
        if (cnt_we[1]) nxt_o = wdata;
    end

    // Control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_e_q <= '0;
            ctl_o_q <= '0;
        end else begin
            if (ctl_we[0]) ctl_e_q <= wr_ctl;
            if (ctl_we[1]) ctl_o_q <= wr_ctl;
        end
    end

    // Fuse state: captured when the even counter is enabled, dropped on teardown
    always_ff @(posedge clk) begin
        if (!rst_n)
            fused_q <= 1'b0;
        else if (ctl_we[0])
            fused_q <= wr_ctl.en && odd_setup;
        else if (ctl_we[1] && !is_fuse_setup(wr_ctl))
            fused_q <= 1'b0;
    end

    // Count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_e_q <= '0;
            cnt_o_q <= '0;
        end else begin
            cnt_e_q <= nxt_e;
            cnt_o_q <= nxt_o;
        end
    end

endmodule

// File: rtl/evctr_rdmux.sv
// Read-data selection for the counter bank.
// Assumes NUM_CTR is even so every even counter has an odd partner.
module evctr_rdmux #(
    parameter int NUM_CTR = 6,
    parameter int CTR_W   = 48,
    parameter int EXT_W   = 16,
    localparam int IDX_W  = $clog2(NUM_CTR),
    localparam int ADDR_W = IDX_W + 1,
    localparam int DATA_W = CTR_W + EXT_W,
    localparam int NUM_PAIR = NUM_CTR / 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  evctr_pkg::ctl_t   ctl_all [NUM_CTR],
    input  logic [CTR_W-1:0]  cnt_all [NUM_CTR],
    input  logic [NUM_PAIR-1:0] fused_all,
    output logic [DATA_W-1:0] rdata
);
    logic [IDX_W-1:0] rd_idx;
    assign rd_idx = addr[ADDR_W-1:1];

    // Pick control or count of the addressed counter; out of range reads zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                if (!addr[0])
                    rdata = DATA_W'(ctl_all[i]);
                else if ((i % 2 == 0) && fused_all[i/2])
                    rdata = {cnt_all[i | 1][EXT_W-1:0], cnt_all[i]};
                else
                    rdata = DATA_W'(cnt_all[i]);
            end
        end
    end

endmodule

// File: rtl/evctr_bank.sv
// Bank of event counters with pairwise fusing into 64-bit wide counters.
// Assumes NUM_CTR is even and EXT_W <= CTR_W; one register access per cycle.
module evctr_bank #(
    parameter int NUM_CTR = 6,
    parameter int CTR_W   = 48,
    parameter int EXT_W   = 16,
    parameter int INC_W   = 4,
    localparam int IDX_W  = $clog2(NUM_CTR),
    localparam int ADDR_W = IDX_W + 1,
    localparam int DATA_W = CTR_W + EXT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic [NUM_CTR*INC_W-1:0] ev_inc
);
    localparam int NUM_PAIR = NUM_CTR / 2;

    evctr_pkg::ctl_t      ctl_all [NUM_CTR];
    logic [CTR_W-1:0]     cnt_all [NUM_CTR];
    logic [NUM_PAIR-1:0]  fused_all;
    logic [NUM_CTR-1:0]   ctl_we;
    logic [NUM_CTR-1:0]   cnt_we;
    logic                 unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CTR_W];

    // Address decode into per-counter write strobes
    always_comb begin
        for (int i = 0; i < NUM_CTR; i++) begin
            ctl_we[i] = reg_we && !reg_addr[0] && (reg_addr[ADDR_W-1:1] == IDX_W'(i));
            cnt_we[i] = reg_we &&  reg_addr[0] && (reg_addr[ADDR_W-1:1] == IDX_W'(i));
        end
    end

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
        evctr_pair #(
            .CTR_W (CTR_W),
            .EXT_W (EXT_W),
            .INC_W (INC_W)
        ) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_we   ({ctl_we[2*p+1], ctl_we[2*p]}),
            .cnt_we   ({cnt_we[2*p+1], cnt_we[2*p]}),
            .wdata    (reg_wdata[CTR_W-1:0]),
            .inc_even (ev_inc[(2*p)*INC_W +: INC_W]),
            .inc_odd  (ev_inc[(2*p+1)*INC_W +: INC_W]),
            .ctl_e_q  (ctl_all[2*p]),
            .ctl_o_q  (ctl_all[2*p+1]),
            .cnt_e_q  (cnt_all[2*p]),
            .cnt_o_q  (cnt_all[2*p+1]),
            .fused_q  (fused_all[p])
        );
    end

    evctr_rdmux #(
        .NUM_CTR (NUM_CTR),
        .CTR_W   (CTR_W),
        .EXT_W   (EXT_W)
    ) u_rdmux (
        .addr      (reg_addr),
        .ctl_all   (ctl_all),
        .cnt_all   (cnt_all),
        .fused_all (fused_all),
        .rdata     (reg_rdata)
    );

endmodule

// File: rtl/evctr_bank_chk.sv
// Property checker for evctr_bank, attached by bind below.
// Observes the register port, the inputs and the per-pair register outputs.
module evctr_bank_chk #(
    parameter int NUM_CTR = 6,
    parameter int CTR_W   = 48,
    parameter int EXT_W   = 16,
    parameter int INC_W   = 4,
    localparam int IDX_W  = $clog2(NUM_CTR),
    localparam int ADDR_W = IDX_W + 1,
    localparam int DATA_W = CTR_W + EXT_W,
    localparam int NUM_PAIR = NUM_CTR / 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_we,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [DATA_W-1:0]        reg_rdata,
    input logic [NUM_CTR*INC_W-1:0] ev_inc,
    input evctr_pkg::ctl_t          ctl_all [NUM_CTR],
    input logic [CTR_W-1:0]         cnt_all [NUM_CTR],
    input logic [NUM_PAIR-1:0]      fused_all
);
    import evctr_pkg::*;

    logic [NUM_CTR-1:0] cnt_wr;

    // Count-register write strobes seen from the port
    always_comb begin
        for (int i = 0; i < NUM_CTR; i++)
            cnt_wr[i] = reg_we && (reg_addr == {IDX_W'(i), 1'b1});
    end

    // R12
    out_of_range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr[ADDR_W-1:1]) >= NUM_CTR) |-> (reg_rdata == '0));

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        // R1
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (cnt_all[i] == '0 && ctl_all[i] == '0));
        // R4
        disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctl_all[i].en && !cnt_wr[i]) |=> $stable(cnt_all[i]));
    end

    for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pr
        localparam int E = 2 * p;
        localparam int O = 2 * p + 1;

        // R3
        even_plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!fused_all[p] && ctl_all[E].en && !cnt_wr[E])
            |=> cnt_all[E] == $past(cnt_all[E]) + CTR_W'($past(ev_inc[E*INC_W +: INC_W])));
        // R3
        odd_plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!fused_all[p] && ctl_all[O].en && !is_fuse_setup(ctl_all[O]) && !cnt_wr[O])
            |=> cnt_all[O] == $past(cnt_all[O]) + CTR_W'($past(ev_inc[O*INC_W +: INC_W])));
        // R5
        odd_setup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!fused_all[p] && is_fuse_setup(ctl_all[O]) && !cnt_wr[O])
            |=> $stable(cnt_all[O]));
        // R6
        fused_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fused_all[p] && ctl_all[E].en && !cnt_wr[E] && !cnt_wr[O])
            |=> {cnt_all[O][EXT_W-1:0], cnt_all[E]}
                == $past({cnt_all[O][EXT_W-1:0], cnt_all[E]})
                 + DATA_W'($past(ev_inc[E*INC_W +: INC_W]))
                 + DATA_W'($past(ev_inc[O*INC_W +: INC_W])));
        // R7
        fuse_needs_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fused_all[p]) |-> $past(is_fuse_setup(ctl_all[O])));
        // R11
        fused_implies_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fused_all[p] |-> (ctl_all[E].en && is_fuse_setup(ctl_all[O])));
    end

endmodule

bind evctr_bank evctr_bank_chk #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .EXT_W   (EXT_W),
    .INC_W   (INC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .ev_inc    (ev_inc),
    .ctl_all   (ctl_all),
    .cnt_all   (cnt_all),
    .fused_all (fused_all)
);

// File: tb/tb_evctr_bank.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a bench-side model built from the requirements.
module tb_evctr_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [23:0] ev_inc = '0;

    int n_run = 0;
    int n_fail = 0;

    logic [20:0] m_ctl [6];
    logic [47:0] m_cnt [6];
    logic        m_fus [3];

    evctr_bank dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ev_inc    (ev_inc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    function automatic logic setup_code(input logic [20:0] c);
        return c[20] && ({c[19:16], c[7:0]} == 12'hFFF);
    endfunction

    function automatic logic [63:0] exp_read(input logic [3:0] a);
        int k;
        k = int'(a[3:1]);
        if (k >= 6) return 64'h0;
        if (!a[0]) return {43'h0, m_ctl[k]};
        if (k % 2 == 0 && m_fus[k/2]) return {m_cnt[k+1][15:0], m_cnt[k]};
        return {16'h0, m_cnt[k]};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Read one register combinationally (no clock edge passes) and compare
    task automatic rd_chk(input logic [3:0] a, input string req);
        reg_we = 1'b0;
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp_read(a));
    endtask

    task automatic clear_model();
        for (int i = 0; i < 6; i++) begin
            m_ctl[i] = '0;
            m_cnt[i] = '0;
        end
        for (int p = 0; p < 3; p++) m_fus[p] = 1'b0;
    endtask

    // One clock: drive inputs, advance the model, wait past the edge
    task automatic step(input logic we, input logic [3:0] a, input logic [63:0] d,
                        input logic [23:0] inc);
        logic [47:0] nn [6];
        logic        nf [3];
        logic [63:0] full;
        int          k;
        logic        ok;
        reg_we = we; reg_addr = a; reg_wdata = d; ev_inc = inc;
        k  = int'(a[3:1]);
        ok = we && (k < 6);
        for (int i = 0; i < 6; i++) nn[i] = m_cnt[i];
        for (int p = 0; p < 3; p++) begin
            int  e;
            int  o;
            logic pw;
            e = 2*p; o = 2*p + 1;
            pw = ok && a[0] && (k == e || k == o);
            nf[p] = m_fus[p];
            if (m_fus[p]) begin
                if (m_ctl[e][20] && !pw) begin
                    full = {m_cnt[o][15:0], m_cnt[e]} + 64'(inc[e*4 +: 4]) + 64'(inc[o*4 +: 4]);
                    nn[e] = full[47:0];
                    nn[o][15:0] = full[63:48];
                end
            end else begin
                if (m_ctl[e][20]) nn[e] = m_cnt[e] + 48'(inc[e*4 +: 4]);
                if (m_ctl[o][20] && !setup_code(m_ctl[o])) nn[o] = m_cnt[o] + 48'(inc[o*4 +: 4]);
            end
            if (ok && !a[0] && k == e) nf[p] = d[20] && setup_code(m_ctl[o]);
            else if (ok && !a[0] && k == o && !setup_code(d[20:0])) nf[p] = 1'b0;
        end
        if (ok && a[0]) nn[k] = d[47:0];
        if (ok && !a[0]) m_ctl[k] = d[20:0];
        for (int i = 0; i < 6; i++) m_cnt[i] = nn[i];
        for (int p = 0; p < 3; p++) m_fus[p] = nf[p];
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        step(1'b1, a, d, 24'h0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        reg_we = 1'b0;
        ev_inc = '0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
    endtask

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything zero after reset
        for (int a = 0; a < 12; a++) rd_chk(4'(a), "R1 reset");

        // R2: control field readback, upper write bits dropped
        wr(4'd0, 64'hFFFF_FFFF_FFE5_A7C3);
        rd_chk(4'd0, "R2 ctl fields");
        chk("R2 high bits zero", reg_rdata[63:21], 43'h0);
        wr(4'd0, 64'h0);

        // R12: out-of-range index ignored on write and reads zero
        wr(4'd13, 64'h1234_5678);
        wr(4'd12, 64'h1F_00FF);
        rd_chk(4'd13, "R12 oor read");
        rd_chk(4'd12, "R12 oor read");
        for (int a = 0; a < 12; a++) rd_chk(4'(a), "R12 oor write ignored");

        // R3: plain odd counter, then wrap at 2^48
        wr(4'd2, 64'h10_FF0C);
        for (int n = 0; n < 5; n++) step(1'b0, 4'd0, 64'h0, 24'h0000_70);
        rd_chk(4'd3, "R3 count");
        chk("R3 five x seven", reg_rdata, 64'd35);
        wr(4'd3, 64'h0000_FFFF_FFFF_FFFD);
        step(1'b0, 4'd0, 64'h0, 24'h0000_50);
        rd_chk(4'd3, "R3 wrap");
        chk("R3 wrap value", reg_rdata, 64'd2);

        // R4: disabled counter holds while inputs toggle
        wr(4'd2, 64'h00_FF0C);
        for (int n = 0; n < 4; n++) step(1'b0, 4'd0, 64'h0, 24'hFFFFFF);
        rd_chk(4'd3, "R4 hold");
        rd_chk(4'd1, "R4 hold");

        // R5/R6: fuse pair 1 (counters 2,3) and cross bit 47
        wr(4'd6, 64'h1F_40FF);
        for (int n = 0; n < 3; n++) step(1'b0, 4'd0, 64'h0, 24'h00F000);
        rd_chk(4'd7, "R5 odd setup idle");
        wr(4'd5, 64'h0000_FFFF_FFFF_FFF6);
        wr(4'd7, 64'h1234);
        wr(4'd4, 64'h10_FF03);
        step(1'b0, 4'd0, 64'h0, 24'h00FF00);
        rd_chk(4'd5, "R6 fused carry");
        chk("R6 fused value", reg_rdata, 64'h1235_0000_0000_0014);
        rd_chk(4'd7, "R9 odd holds top field");
        for (int n = 0; n < 6; n++) step(1'b0, 4'd0, 64'h0, 24'h00A500);
        rd_chk(4'd5, "R8 fused 64-bit read");

        // R9: even write touches low 48 only; top through odd register
        wr(4'd5, 64'hABCD_0000_0000_0100);
        rd_chk(4'd5, "R9 low write");
        wr(4'd7, 64'hFFFF_0000_0000_00EE);
        rd_chk(4'd5, "R9 top write");

        // R10: write to either half drops the pair increment
        step(1'b1, 4'd7, 64'h7, 24'h00FF00);
        rd_chk(4'd5, "R10 pair write drop");
        step(1'b1, 4'd5, 64'h40, 24'h00FF00);
        rd_chk(4'd5, "R10 pair write drop");

        // R7: wrong order on pair 2, then re-enable fuses it
        wr(4'd8, 64'h10_0003);
        wr(4'd10, 64'h1F_00FF);
        for (int n = 0; n < 3; n++) step(1'b0, 4'd0, 64'h0, 24'h330000);
        rd_chk(4'd9, "R7 stays plain");
        chk("R7 plain value", reg_rdata, 64'd9);
        wr(4'd8, 64'h10_0003);
        step(1'b0, 4'd0, 64'h0, 24'h330000);
        rd_chk(4'd9, "R7 fused after re-enable");
        chk("R7 fused value", reg_rdata, 64'd15);

        // R11: teardown by odd rewrite and by even disable
        wr(4'd6, 64'h10_0011);
        rd_chk(4'd5, "R11 odd teardown");
        step(1'b0, 4'd0, 64'h0, 24'h00F100);
        rd_chk(4'd7, "R11 odd counts again");
        wr(4'd8, 64'h0);
        rd_chk(4'd9, "R11 even disable");

        // R1: mid-run reset clears state
        do_reset();
        for (int a = 0; a < 12; a++) rd_chk(4'(a), "R1 mid reset");

        // Random traffic, seeded
        begin
            int unsigned seed = 32'd11;
            logic [63:0] d;
            logic [3:0]  a;
            void'($urandom(seed));
            for (int n = 0; n < 4000; n++) begin
                a = 4'($urandom_range(0, 15));
                d = {$urandom, $urandom};
                if (!a[0] && ($urandom_range(0, 1) == 1)) d = {43'h0, 1'b1, 4'hF, d[15:8], 8'hFF};
                if (a[0] && ($urandom_range(0, 3) == 0)) d[47:0] = 48'hFFFF_FFFF_FFF0 | 48'(d[3:0]);
                step($urandom_range(0, 3) == 0, a, d, 24'($urandom));
                a = 4'($urandom_range(0, 15));
                if (a[3:1] >= 3'd6) rd_chk(a, "R12 random read");
                else if (!a[0]) rd_chk(a, "R2 random read");
                else rd_chk(a, "R8 random read");
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule